// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Capture Register

This block gathers a serial bit stream into a 48-bit word on a shift clock and delivers each completed word to a second, unrelated transfer clock. In the transfer domain the word appears as a stable parallel output. A bit counter in the shift domain marks the 48th bit. At that point the finished word is copied into a holding register, and a toggling request flag announces it.

The transfer side synchronizes the request through two flops and turns the toggle into a one-cycle pulse. A three-state sequencer then loads the parallel output from the holding register and toggles an acknowledge flag, which is synchronized back into the shift domain.

The shift-side sequencer has two states:
- SH_IDLE: the holding register is free.
- SH_WAIT: a request is outstanding.

It moves from SH_IDLE to SH_WAIT when a word completes, and back to SH_IDLE when the synchronized acknowledge equals the request. A word that completes during SH_WAIT is discarded and raises a sticky overrun flag.

The transfer-side sequencer steps through three states:
- XF_IDLE, which it leaves on the request pulse;
- XF_LOAD, where the parallel word is written;
- XF_ACK, where the acknowledge toggles.

It then returns to XF_IDLE.

Top module: `sercap_top`

## Requirements
- R1: An active-high asynchronous reset clears the shift word, the parallel word, the overrun flag, the bit counter, the holding register and both handshake flags, without waiting for any clock edge.
- R2: On each rising shift-clock edge with mode_sel low, the shift word becomes {shift_word[46:0], ser_in}: exactly one new bit enters bit 0 and older bits move toward bit 47.
- R3: On a rising shift-clock edge with mode_sel high, the shift word and the bit count keep their values, so the bits presented then do not appear in any delivered word.
- R4: shift_en is high exactly when mode_sel is low and shift_clk is high.
- R5: Every 48 accepted bits form one word. The first accepted bit is bit 47 and the last is bit 0. That word is delivered unchanged to par_word through the handshake.
- R6: par_word changes only in the transfer sequencer's load step. Between loads it holds its value, including while the transfer clock is stopped.
- R7: A word that completes while a request is still outstanding is dropped without touching the holding register, and ovr_flag goes high and stays high until reset.
- R8: After an overrun, the word already held is still delivered once the transfer side runs, and later words are delivered normally.
- R9: The bit counter stays within 0 to 47 and returns to 0 after the 48th accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; serial bits are taken on its rising edge |
| xfer_clk | input | 1 | Transfer clock that owns the parallel output |
| arst | input | 1 | Asynchronous active-high reset for both domains |
| ser_in | input | 1 | Serial data bit |
| mode_sel | input | 1 | High pauses shifting; low lets bits in |
| shift_word | output | 48 | Live contents of the shift register |
| par_word | output | 48 | Last word delivered to the transfer domain |
| shift_en | output | 1 | High while shifting is allowed and shift_clk is high |
| ovr_flag | output | 1 | Sticky flag for a word dropped on overrun |

## Verification
The shift word and the overrun flag change on the shift edge that accepts a bit, so the bench samples them half a shift period after that edge. shift_en is combinational and is sampled inside the high phase of shift_clk.

The parallel word lands on about the fourth transfer edge after the request toggle: two synchronizer flops, the XF_IDLE to XF_LOAD step, and then the load. That delay is not tied to the shift clock, so the bench does not predict the exact cycle. A scoreboard queue holds each expected word, and a monitor compares every change of par_word, observed on the falling transfer edge, with the head of the queue. Idle shift periods give the handshake time to finish, and an empty queue is required at the end.

// File: rtl/sercap_pkg.sv
package sercap_pkg;

    localparam int unsigned WORD_W_DEF = 48;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        SH_IDLE,
        SH_WAIT
    } sh_state_e;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_LOAD = 2'd1,
        XF_ACK  = 2'd2
    } xf_state_e;

endpackage

// File: rtl/sercap_sync.sv
module sercap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/sercap_shift_side.sv
module sercap_shift_side
    import sercap_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              shift_clk,
    input  logic              arst,
    input  logic              ser_in,
    input  logic              mode_sel,
    input  logic              ack_tgl,
    output logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] hold_word,
    output logic              req_tgl,
    output logic              ovr_flag,
    output logic              busy,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    sh_state_e state, state_nx;
    logic      ack_s;
    logic      accept;
    logic      word_done;
    logic [WORD_W-1:0] next_word;

    sercap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (shift_clk),
        .arst  (arst),
        .d_in  (ack_tgl),
        .q_out (ack_s)
    );

    assign accept    = !mode_sel;
    assign word_done = accept && (bit_cnt == LAST_BIT);
    assign next_word = {shift_word[WORD_W-2:0], ser_in};
    assign busy      = (state == SH_WAIT);

    always_ff @(posedge shift_clk or posedge arst) begin
        if (arst) state <= SH_IDLE;
        else      state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: if (word_done)         state_nx = SH_WAIT;
            SH_WAIT: if (ack_s == req_tgl)  state_nx = SH_IDLE;
            default:                        state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge shift_clk or posedge arst) begin
        if (arst) begin
            shift_word <= '0;
            bit_cnt    <= '0;
            hold_word  <= '0;
            req_tgl    <= 1'b0;
            ovr_flag   <= 1'b0;
        end else begin
            if (accept) begin
                shift_word <= next_word;
                bit_cnt    <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            end
            if (word_done) begin
                if (state == SH_IDLE) begin
                    hold_word <= next_word;
                    req_tgl   <= ~req_tgl;
                end else begin
                    ovr_flag  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sercap_xfer_side.sv
module sercap_xfer_side
    import sercap_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              xfer_clk,
    input  logic              arst,
    input  logic              req_tgl,
    input  logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] par_word,
    output logic              ack_tgl,
    output logic              req_pulse,
    output logic              load_en
);
    xf_state_e state, state_nx;
    logic      req_s;
    logic      req_d;

    sercap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (xfer_clk),
        .arst  (arst),
        .d_in  (req_tgl),
        .q_out (req_s)
    );

    always_ff @(posedge xfer_clk or posedge arst) begin
        if (arst) req_d <= 1'b0;
        else      req_d <= req_s;
    end

    assign req_pulse = req_s ^ req_d;
    assign load_en   = (state == XF_LOAD);

    always_ff @(posedge xfer_clk or posedge arst) begin
        if (arst) state <= XF_IDLE;
        else      state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (req_pulse) state_nx = XF_LOAD;
            XF_LOAD:                state_nx = XF_ACK;
            XF_ACK:                 state_nx = XF_IDLE;
            default:                state_nx = XF_IDLE;
        endcase
    end

    always_ff @(posedge xfer_clk or posedge arst) begin
        if (arst) begin
            par_word <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            unique case (state)
                XF_LOAD: par_word <= hold_word;
                XF_ACK:  ack_tgl  <= ~ack_tgl;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sercap_top.sv
module sercap_top
    import sercap_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              shift_clk,
    input  logic              xfer_clk,
    input  logic              arst,
    input  logic              ser_in,
    input  logic              mode_sel,
    output logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] par_word,
    output logic              shift_en,
    output logic              ovr_flag
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] hold_word;
    logic              req_tgl;
    logic              ack_tgl;
    logic              busy;
    logic              req_pulse;
    logic              load_en;
    logic [CNT_W-1:0]  bit_cnt;

    assign shift_en = !mode_sel && shift_clk;

    sercap_shift_side #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .shift_clk  (shift_clk),
        .arst       (arst),
        .ser_in     (ser_in),
        .mode_sel   (mode_sel),
        .ack_tgl    (ack_tgl),
        .shift_word (shift_word),
        .hold_word  (hold_word),
        .req_tgl    (req_tgl),
        .ovr_flag   (ovr_flag),
        .busy       (busy),
        .bit_cnt    (bit_cnt)
    );

    sercap_xfer_side #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .xfer_clk  (xfer_clk),
        .arst      (arst),
        .req_tgl   (req_tgl),
        .hold_word (hold_word),
        .par_word  (par_word),
        .ack_tgl   (ack_tgl),
        .req_pulse (req_pulse),
        .load_en   (load_en)
    );
endmodule

// File: rtl/sercap_chk.sv
module sercap_chk #(
    parameter int unsigned WORD_W = 48,
    parameter int unsigned CNT_W = 6
) (
    input logic              shift_clk,
    input logic              xfer_clk,
    input logic              arst,
    input logic              ser_in,
    input logic              mode_sel,
    input logic [WORD_W-1:0] shift_word,
    input logic [WORD_W-1:0] par_word,
    input logic [WORD_W-1:0] hold_word,
    input logic              ovr_flag,
    input logic              busy,
    input logic              req_pulse,
    input logic              load_en,
    input logic [CNT_W-1:0]  bit_cnt
);
    assert_shift_one_bit_R2: assert property (@(posedge shift_clk) disable iff (arst)
        !mode_sel |=> (shift_word == {$past(shift_word[WORD_W-2:0]), $past(ser_in)}));

    assert_freeze_R3: assert property (@(posedge shift_clk) disable iff (arst)
        mode_sel |=> ($stable(shift_word) && $stable(bit_cnt)));

    assert_pulse_loads_R5: assert property (@(posedge xfer_clk) disable iff (arst)
        req_pulse |=> load_en);

    assert_par_stable_R6: assert property (@(posedge xfer_clk) disable iff (arst)
        !load_en |=> $stable(par_word));

    assert_hold_kept_R7: assert property (@(posedge shift_clk) disable iff (arst)
        busy |=> $stable(hold_word));

    assert_ovr_sticky_R7: assert property (@(posedge shift_clk) disable iff (arst)
        ovr_flag |=> ovr_flag);

    assert_cnt_range_R9: assert property (@(posedge shift_clk) disable iff (arst)
        bit_cnt <= CNT_W'(WORD_W - 1));
endmodule

bind sercap_top sercap_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .shift_clk  (shift_clk),
    .xfer_clk   (xfer_clk),
    .arst       (arst),
    .ser_in     (ser_in),
    .mode_sel   (mode_sel),
    .shift_word (shift_word),
    .par_word   (par_word),
    .hold_word  (hold_word),
    .ovr_flag   (ovr_flag),
    .busy       (busy),
    .req_pulse  (req_pulse),
    .load_en    (load_en),
    .bit_cnt    (bit_cnt)
);

// File: tb/tb_sercap_top.sv
module tb_sercap_top;
    localparam int W = 48;

    logic shift_clk = 1'b0;
    logic xfer_clk = 1'b0;
    logic arst = 1'b1;
    logic ser_in = 1'b0;
    logic mode_sel = 1'b1;
    logic xrun = 1'b1;
    logic [W-1:0] shift_word, par_word;
    logic shift_en, ovr_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_par = '0;
    logic en_hi_sample;

    sercap_top dut (
        .shift_clk  (shift_clk),
        .xfer_clk   (xfer_clk),
        .arst       (arst),
        .ser_in     (ser_in),
        .mode_sel   (mode_sel),
        .shift_word (shift_word),
        .par_word   (par_word),
        .shift_en   (shift_en),
        .ovr_flag   (ovr_flag)
    );

    // 125 MHz transfer clock that can be paused in the low phase
    initial forever begin
        #4;
        if (xrun || xfer_clk) xfer_clk = ~xfer_clk;
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one shift period of 10 ns; shift_en sampled in the high phase
    task automatic tick(input logic b, input logic m);
        mode_sel = m;
        ser_in   = b;
        #5 shift_clk = 1'b1;
        #2 en_hi_sample = shift_en;
        #3 shift_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [W-1:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) tick(w[i], 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
    endtask

    // monitor: every change of par_word must match the scoreboard head
    always @(negedge xfer_clk) begin
        if (arst) begin
            last_par = '0;
        end else if (par_word !== last_par) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected load", par_word, last_par);
            end else begin
                check("R5 delivered word", par_word, exp_q.pop_front());
            end
            last_par = par_word;
        end
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [W-1:0] wa, wb, wc, wd, we, wf, snap;
        wa = 48'hA5C3_1F00_7E91;
        wb = 48'h1234_5678_9ABC;
        wc = 48'h0F0F_F0F0_55AA;
        wd = 48'hDEAD_BEEF_0123;
        we = 48'h8000_0000_0001;
        wf = 48'h3C3C_0000_FFFF;

        #20;
        check("R1 reset shift_word", shift_word, '0);
        check("R1 reset par_word", par_word, '0);
        check("R1 reset ovr_flag", {47'd0, ovr_flag}, '0);
        arst = 1'b0;
        #10;

        // R4: shift_en gating
        tick(1'b1, 1'b1);
        check("R4 shift_en with mode_sel high", {47'd0, en_hi_sample}, '0);
        check("R4 shift_en with clock low", {47'd0, shift_en}, '0);

        // R2: first three bits enter at bit 0
        send_bits(wa, 47, 45);
        check("R4 shift_en with mode_sel low", {47'd0, en_hi_sample}, 48'd1);
        check("R2 partial shift", shift_word, {45'd0, wa[47:45]});
        send_bits(wa, 44, 0);
        exp_q.push_back(wa);
        check("R2 full word in shift register", shift_word, wa);
        idle(20);

        // R3: bits offered with mode_sel high are ignored
        send_bits(wb, 47, 28);
        snap = shift_word;
        tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
        tick(1'b1, 1'b1); tick(1'b0, 1'b1);
        check("R3 shift_word frozen", shift_word, snap);
        send_bits(wb, 27, 0);
        exp_q.push_back(wb);
        idle(20);

        // R5/R9: back-to-back words, counter wraps cleanly
        send_bits(wc, 47, 0);
        exp_q.push_back(wc);
        idle(20);
        check("R7 no overrun in normal flow", {47'd0, ovr_flag}, '0);

        // R7/R8: stop transfer clock, complete two words
        xrun = 1'b0;
        #20;
        snap = par_word;
        send_bits(wd, 47, 0);
        exp_q.push_back(wd);
        send_bits(we, 47, 0);
        check("R7 overrun flag set", {47'd0, ovr_flag}, 48'd1);
        check("R6 par_word held while clock stopped", par_word, snap);
        xrun = 1'b1;
        idle(20);
        check("R8 held word delivered after overrun", par_word, wd);
        send_bits(wf, 47, 0);
        exp_q.push_back(wf);
        idle(20);
        check("R8 next word after overrun", par_word, wf);
        check("R7 overrun flag sticky", {47'd0, ovr_flag}, 48'd1);
        check("R5 scoreboard drained", W'(exp_q.size()), '0);

        // R1: asynchronous reset mid-word, no clock edge
        send_bits(wa, 47, 38);
        #2 arst = 1'b1;
        #1;
        check("R1 async clear shift_word", shift_word, '0);
        check("R1 async clear par_word", par_word, '0);
        check("R1 async clear ovr_flag", {47'd0, ovr_flag}, '0);
        #10;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule